// File: doc/BRIEF.md
# Timer Capture, Compare and PWM Channel

This block is one channel attached to a free-running timer. A single 16-bit data register is shared by three kinds of behaviour, and a 4-bit mode field in an 8-bit control register picks one of them. In capture modes the channel latches the timer value when a qualifying input edge arrives. An optional prescaler counts 1, 4 or 16 edges before each capture. Either a synchronised pin or a synchronous message-received strobe can trigger a capture. In compare modes the channel watches for the timer to reach the stored value. It then toggles, sets or clears its output pin, only raises the event flag, or also pulses a timer-reset strobe. In PWM modes the low byte of the data register and two control bits form a 10-bit duty value. The channel compares that value against a 10-bit counter made of the timer's low byte and two sub-count bits.

Register writes arrive as byte strobes with one write-data byte. The interrupt flag stays set until it is cleared. Changing the mode re-initialises the pin state and the prescale counter.

Top module: `ccp_channel`

## Requirements
- R1: After reset, ctrl_o, data_o, flag_o, pin_o, pin_oe_o and tmr_rst_o are all 0.
- R2: A control write stores wdata_i[5:4] as the two low duty bits and wdata_i[3:0] as the mode. ctrl_o reads back {2'b00, duty_low, mode}, so writing 8'hFF reads back 8'h3F.
- R3: Modes 4'b0000, 4'b0001 and 4'b0011 leave the pin undriven (pin_oe_o=0, pin_o=0). In these modes pin edges and timer matches neither capture nor set the flag. Entering any new mode clears the prescale counter and the compare pin state.
- R4: Mode 4'b0101 captures on each rising pin edge and mode 4'b0100 on each falling edge. If the pin changes before clock edge k, data_o takes the tmr_i value present at edge k+2 and flag_o is set at that same edge. Edges of the other polarity are ignored.
- R5: Mode 4'b0110 captures on every 4th rising edge and mode 4'b0111 on every 16th. Writing a different mode restarts the edge count from zero.
- R6: In a capture mode with alt_sel_i=1, a one-cycle alt_evt_i pulse replaces the pin as the event source. The capture happens at the same clock edge that samples the pulse, pin edges are ignored, and the same prescale count applies.
- R7: Mode 4'b0010 toggles the pin on each compare match and sets the flag. The pin starts at 0 when the mode is entered.
- R8: Mode 4'b1000 drives the pin 0 on entry and 1 on a match. Mode 4'b1001 drives it 1 on entry and 0 on a match. Both modes set the flag on a match.
- R9: Mode 4'b1010 only sets the flag on a match, with pin_oe_o=0. Mode 4'b1011 also sets the flag, keeps pin_oe_o=0 and raises tmr_rst_o for exactly the one cycle after the match edge.
- R10: A compare match is the first clock edge at which tmr_i equals data_o after a cycle where it did not. A timer held at the match value acts only once.
- R11: Modes 4'b11xx drive a PWM output. At an edge with period_start_i=1, the duty value {data_o[7:0], duty_low} is loaded and the pin goes high if that value is nonzero. The pin falls at the edge where {tmr_i[7:0], tmr_sub_i} equals the loaded duty. Duty writes take effect only at the next period start.
- R12: flag_o stays 1 until a cycle with flag_clr_i=1. A new event in the same cycle as a clear leaves the flag set.
- R13: dlo_we_i writes wdata_i into data bits 7:0 and dhi_we_i into bits 15:8. A register write in the same cycle as a capture takes priority over the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_i | input | 16 | Free-running timer count |
| tmr_sub_i | input | 2 | Timer prescale bits, low end of the PWM counter |
| period_start_i | input | 1 | PWM period boundary strobe |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| alt_sel_i | input | 1 | Selects the message strobe as capture source |
| alt_evt_i | input | 1 | Synchronous message-received strobe |
| ctrl_we_i | input | 1 | Control register write strobe |
| dlo_we_i | input | 1 | Data register low byte write strobe |
| dhi_we_i | input | 1 | Data register high byte write strobe |
| wdata_i | input | 8 | Write data byte |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| ctrl_o | output | 8 | Control register readback |
| data_o | output | 16 | Data register readback |
| pin_o | output | 1 | Output pin level |
| pin_oe_o | output | 1 | Output pin drive enable |
| flag_o | output | 1 | Sticky interrupt flag |
| tmr_rst_o | output | 1 | One-cycle timer reset strobe |

## Verification
The assertions assume the following about the inputs:
- alt_evt_i is already synchronous to the clock.
- period_start_i coincides with a PWM counter of zero, so a rising PWM pin can only follow a period strobe.
- The flag can be cleared only through flag_clr_i, and the data register moves only on a write or a capture.

The directed stimulus holds every pin level for at least two cycles and pulses the message strobe for a single cycle. A later randomised phase toggles the pin on any cycle and writes modes at random; a behavioural model in the bench tracks those cases cycle by cycle.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
package ccp_pkg;
  localparam int DUTY_LO_W = 2;

  localparam logic [3:0] M_OFF      = 4'b0000;
  localparam logic [3:0] M_CMP_TGL  = 4'b0010;
  localparam logic [3:0] M_CAP_FALL = 4'b0100;
  localparam logic [3:0] M_CAP_RISE = 4'b0101;
  localparam logic [3:0] M_CAP_4    = 4'b0110;
  localparam logic [3:0] M_CAP_16   = 4'b0111;
  localparam logic [3:0] M_CMP_SET  = 4'b1000;
  localparam logic [3:0] M_CMP_CLR  = 4'b1001;
  localparam logic [3:0] M_CMP_EVT  = 4'b1010;
  localparam logic [3:0] M_CMP_TRG  = 4'b1011;

  function automatic logic is_capture(logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic is_compare(logic [3:0] m);
    return (m == M_CMP_TGL) || (m[3:2] == 2'b10);
  endfunction

  function automatic logic is_pwm(logic [3:0] m);
    return m[3:2] == 2'b11;
  endfunction

  function automatic logic drives_pin(logic [3:0] m);
    return (m == M_CMP_TGL) || (m[3:1] == 3'b100) || is_pwm(m);
  endfunction

  function automatic logic [4:0] cap_limit(logic [3:0] m);
    case (m)
      M_CAP_4:  return 5'd4;
      M_CAP_16: return 5'd16;
      default:  return 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/ccp_capture.sv
`timescale 1ns/1ps
module ccp_capture import ccp_pkg::*; #(
  parameter int SYNC_N = 2,
  parameter int CNT_W  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       alt_sel_i,
  input  logic       alt_evt_i,
  input  logic [3:0] mode_i,
  input  logic       clr_i,
  output logic       cap_o
);
  logic             lvl;
  logic             prev_q;
  logic             rise, fall, ev;
  logic [CNT_W-1:0] cnt_q;
  logic [4:0]       lim;
  logic [CNT_W-1:0] lim_m1;

  if (SYNC_N > 1) begin : g_multi
    logic [SYNC_N-1:0] sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_N-2:0], pin_i};
    end
    assign lvl = sync_q[SYNC_N-1];
  end else begin : g_single
    logic sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= 1'b0;
      else         sync_q <= pin_i;
    end
    assign lvl = sync_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  assign rise   = lvl & ~prev_q;
  assign fall   = ~lvl & prev_q;
  assign ev     = is_capture(mode_i) &&
                  (alt_sel_i ? alt_evt_i : ((mode_i == M_CAP_FALL) ? fall : rise));
  assign lim    = cap_limit(mode_i);
  assign lim_m1 = CNT_W'(lim - 5'd1);
  assign cap_o  = ev && (cnt_q == lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (ev)    cnt_q <= cap_o ? '0 : cnt_q + 1'b1;
  end

  // R5
  prescale_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_capture(mode_i) |-> ({1'b0, cnt_q} < cap_limit(mode_i)));
endmodule

// File: rtl/ccp_compare.sv
`timescale 1ns/1ps
module ccp_compare import ccp_pkg::*; #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] tmr_i,
  input  logic [TMR_W-1:0] ref_i,
  input  logic [3:0]       mode_i,
  input  logic             load_i,
  input  logic [3:0]       load_mode_i,
  output logic             pin_o,
  output logic             evt_o,
  output logic             trig_o
);
  logic match, match_q, pin_q, trig_q;

  assign match = (tmr_i == ref_i);
  // act once per arrival at the match value
  assign evt_o = match && !match_q && is_compare(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      match_q <= match;
      trig_q  <= evt_o && (mode_i == M_CMP_TRG);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else if (load_i) pin_q <= (load_mode_i == M_CMP_CLR);
    else if (evt_o) begin
      case (mode_i)
        M_CMP_TGL: pin_q <= ~pin_q;
        M_CMP_SET: pin_q <= 1'b1;
        M_CMP_CLR: pin_q <= 1'b0;
        default:   pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o  = pin_q;
  assign trig_o = trig_q;

  // R8
  set_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_CMP_SET && !load_i && pin_q) |=> pin_q);
  // R9
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |=> !trig_q);
endmodule

// File: rtl/ccp_pwm.sv
`timescale 1ns/1ps
module ccp_pwm #(
  parameter int PWM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PWM_W-1:0] cnt_i,
  input  logic [PWM_W-1:0] duty_i,
  input  logic             period_i,
  input  logic             en_i,
  input  logic             load_i,
  output logic             pin_o
);
  logic [PWM_W-1:0] duty_q;
  logic             pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      pin_q  <= 1'b0;
    end else if (load_i) begin
      pin_q  <= 1'b0;
    end else if (en_i) begin
      if (period_i) begin
        duty_q <= duty_i;
        pin_q  <= (duty_i != '0);
      end else if (pin_q && cnt_i == duty_q) begin
        pin_q  <= 1'b0;
      end
    end
  end

  assign pin_o = pin_q;

  // R11
  pwm_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_q) |-> $past(period_i));
endmodule

// File: rtl/ccp_channel.sv
`timescale 1ns/1ps
module ccp_channel import ccp_pkg::*; #(
  parameter int TMR_W        = 16,
  parameter int DUTY_HI_W    = 8,
  parameter int SYNC_N       = 2,
  parameter int MAX_PRESCALE = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [TMR_W-1:0]     tmr_i,
  input  logic [DUTY_LO_W-1:0] tmr_sub_i,
  input  logic                 period_start_i,
  input  logic                 cap_pin_i,
  input  logic                 alt_sel_i,
  input  logic                 alt_evt_i,
  input  logic                 ctrl_we_i,
  input  logic                 dlo_we_i,
  input  logic                 dhi_we_i,
  input  logic [7:0]           wdata_i,
  input  logic                 flag_clr_i,
  output logic [7:0]           ctrl_o,
  output logic [TMR_W-1:0]     data_o,
  output logic                 pin_o,
  output logic                 pin_oe_o,
  output logic                 flag_o,
  output logic                 tmr_rst_o
);
  localparam int CNT_W = $clog2(MAX_PRESCALE);
  localparam int HI_W  = TMR_W - 8;
  localparam int PWM_W = DUTY_HI_W + DUTY_LO_W;

  logic [3:0]           mode_q;
  logic [DUTY_LO_W-1:0] dcb_q;
  logic [TMR_W-1:0]     data_q;
  logic                 flag_q;
  logic                 mode_chg;
  logic                 cap_stb, cmp_evt, cmp_pin, cmp_trig, pwm_pin;
  logic                 ctrl_unused;

  assign ctrl_unused = ^wdata_i[7:6];
  assign mode_chg    = ctrl_we_i && (wdata_i[3:0] != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_OFF;
      dcb_q  <= '0;
    end else if (ctrl_we_i) begin
      mode_q <= wdata_i[3:0];
      dcb_q  <= wdata_i[5:4];
    end
  end

  // writes win over a simultaneous capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else if (dlo_we_i || dhi_we_i) begin
      if (dlo_we_i) data_q[7:0]       <= wdata_i;
      if (dhi_we_i) data_q[TMR_W-1:8] <= wdata_i[HI_W-1:0];
    end else if (cap_stb) data_q <= tmr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (cap_stb || cmp_evt) flag_q <= 1'b1;
    else if (flag_clr_i)         flag_q <= 1'b0;
  end

  ccp_capture #(.SYNC_N(SYNC_N), .CNT_W(CNT_W)) u_cap (
    .clk_i, .rst_ni,
    .pin_i(cap_pin_i), .alt_sel_i, .alt_evt_i,
    .mode_i(mode_q), .clr_i(mode_chg), .cap_o(cap_stb)
  );

  ccp_compare #(.TMR_W(TMR_W)) u_cmp (
    .clk_i, .rst_ni, .tmr_i, .ref_i(data_q),
    .mode_i(mode_q), .load_i(mode_chg), .load_mode_i(wdata_i[3:0]),
    .pin_o(cmp_pin), .evt_o(cmp_evt), .trig_o(cmp_trig)
  );

  ccp_pwm #(.PWM_W(PWM_W)) u_pwm (
    .clk_i, .rst_ni,
    .cnt_i({tmr_i[DUTY_HI_W-1:0], tmr_sub_i}),
    .duty_i({data_q[DUTY_HI_W-1:0], dcb_q}),
    .period_i(period_start_i), .en_i(is_pwm(mode_q)),
    .load_i(mode_chg), .pin_o(pwm_pin)
  );

  assign ctrl_o    = {2'b00, dcb_q, mode_q};
  assign data_o    = data_q;
  assign pin_oe_o  = drives_pin(mode_q);
  assign pin_o     = pin_oe_o & (is_pwm(mode_q) ? pwm_pin : cmp_pin);
  assign flag_o    = flag_q;
  assign tmr_rst_o = cmp_trig;

  // R12
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i) |=> flag_q);
  // R13
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dlo_we_i && !dhi_we_i && !is_capture(mode_q)) |=> $stable(data_q));
endmodule

// File: tb/ccp_channel_test.sv
`timescale 1ns/1ps
module ccp_channel_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] tmr_i = '0;
  logic [1:0]  tmr_sub_i = '0;
  logic        period_start_i = 0, cap_pin_i = 0, alt_sel_i = 0, alt_evt_i = 0;
  logic        ctrl_we_i = 0, dlo_we_i = 0, dhi_we_i = 0, flag_clr_i = 0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  ctrl_o;
  logic [15:0] data_o;
  logic        pin_o, pin_oe_o, flag_o, tmr_rst_o;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk_i = ~clk_i;

  ccp_channel uut (.*);

  // reference model
  logic [3:0]  m_mode;
  logic [1:0]  m_dcb;
  logic [15:0] m_data;
  logic        m_flag, m_cpin, m_ppin, m_trig, m_mprev, s1, s2, s3;
  logic [9:0]  m_duty;
  int          m_cnt;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_dcb = 0; m_data = 0; m_flag = 0; m_cpin = 0; m_ppin = 0;
      m_trig = 0; m_mprev = 0; s1 = 0; s2 = 0; s3 = 0; m_duty = 0; m_cnt = 0;
    end else begin : mdl
      logic match, mevt, capm, ev, capt, mchg, en;
      logic [9:0] c10, nd;
      int lim;
      match = (tmr_i == m_data);
      mevt  = match && !m_mprev && ((m_mode == 4'd2) || (m_mode[3:2] == 2'b10));
      capm  = (m_mode[3:2] == 2'b01);
      ev    = capm && (alt_sel_i ? alt_evt_i :
              ((m_mode == 4'd4) ? (!s2 && s3) : (s2 && !s3)));
      lim   = (m_mode == 4'd6) ? 4 : (m_mode == 4'd7) ? 16 : 1;
      capt  = ev && (m_cnt == lim - 1);
      mchg  = ctrl_we_i && (wdata_i[3:0] != m_mode);
      en    = (m_mode[3:2] == 2'b11);
      c10   = {tmr_i[7:0], tmr_sub_i};
      nd    = {m_data[7:0], m_dcb};
      if (mchg) m_cnt = 0;
      else if (ev) m_cnt = capt ? 0 : m_cnt + 1;
      s3 = s2; s2 = s1; s1 = cap_pin_i;
      if (capt || mevt) m_flag = 1;
      else if (flag_clr_i) m_flag = 0;
      if (mchg) m_cpin = (wdata_i[3:0] == 4'd9);
      else if (mevt) begin
        if (m_mode == 4'd2) m_cpin = ~m_cpin;
        else if (m_mode == 4'd8) m_cpin = 1;
        else if (m_mode == 4'd9) m_cpin = 0;
      end
      m_trig  = mevt && (m_mode == 4'd11);
      m_mprev = match;
      if (mchg) m_ppin = 0;
      else if (en) begin
        if (period_start_i) begin m_duty = nd; m_ppin = (nd != 0); end
        else if (m_ppin && c10 == m_duty) m_ppin = 0;
      end
      if (dlo_we_i || dhi_we_i) begin
        if (dlo_we_i) m_data[7:0]  = wdata_i;
        if (dhi_we_i) m_data[15:8] = wdata_i;
      end else if (capt) m_data = tmr_i;
      if (ctrl_we_i) begin m_mode = wdata_i[3:0]; m_dcb = wdata_i[5:4]; end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cmp_all();
    logic oe;
    oe = (m_mode == 4'd2) || (m_mode[3:1] == 3'b100) || (m_mode[3:2] == 2'b11);
    chk({phase, " model ctrl"}, ctrl_o, {2'b00, m_dcb, m_mode});
    chk({phase, " model data"}, data_o, m_data);
    chk({phase, " model oe"}, pin_oe_o, oe);
    chk({phase, " model pin"}, pin_o, oe ? ((m_mode[3:2] == 2'b11) ? m_ppin : m_cpin) : 1'b0);
    chk({phase, " model flag"}, flag_o, m_flag);
    chk({phase, " model trig"}, tmr_rst_o, m_trig);
  endtask

  task automatic step();
    @(negedge clk_i);
    if (rst_ni) cmp_all();
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    ctrl_we_i = 1; wdata_i = v; step(); ctrl_we_i = 0;
  endtask

  task automatic wr_data(logic [15:0] v);
    dlo_we_i = 1; wdata_i = v[7:0]; step(); dlo_we_i = 0;
    dhi_we_i = 1; wdata_i = v[15:8]; step(); dhi_we_i = 0;
  endtask

  task automatic pulse_pin();
    cap_pin_i = 1; step(); step(); cap_pin_i = 0; step(); step();
  endtask

  task automatic clr_flag();
    flag_clr_i = 1; step(); flag_clr_i = 0;
  endtask

  task automatic pwm_run(int len, int duty, int wr_at, logic [7:0] wr_val);
    for (int c = 0; c < len; c++) begin
      tmr_i = {8'h00, 8'(c >> 2)}; tmr_sub_i = 2'(c);
      period_start_i = (c == 0);
      if (c == wr_at) begin dlo_we_i = 1; wdata_i = wr_val; end
      step();
      dlo_we_i = 0; period_start_i = 0;
      chk("R11 pwm level", pin_o, (c < duty));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 ctrl", ctrl_o, 0); chk("R1 data", data_o, 0); chk("R1 flag", flag_o, 0);
    chk("R1 oe", pin_oe_o, 0); chk("R1 pin", pin_o, 0); chk("R1 trig", tmr_rst_o, 0);
    rst_ni = 1;
    step();

    phase = "R2";
    wr_ctrl(8'hFF); chk("R2 ctrl readback", ctrl_o, 8'h3F);
    wr_ctrl(8'h00); chk("R2 ctrl cleared", ctrl_o, 8'h00);

    phase = "R13";
    wr_data(16'hA55A); chk("R13 byte writes", data_o, 16'hA55A);

    phase = "R4";
    wr_ctrl(8'h05);
    tmr_i = 16'd10; cap_pin_i = 1; step();
    tmr_i = 16'd20; step(); chk("R4 not yet captured", data_o, 16'hA55A);
    tmr_i = 16'd30; step(); chk("R4 rise capture", data_o, 16'd30);
    chk("R4 flag", flag_o, 1);
    phase = "R12"; clr_flag(); chk("R12 flag cleared", flag_o, 0);
    phase = "R4";
    cap_pin_i = 0; step(); step(); step();
    chk("R4 fall ignored in rise mode", data_o, 16'd30);
    wr_ctrl(8'h04);
    tmr_i = 16'd40; cap_pin_i = 1; step(); step(); step();
    chk("R4 rise ignored in fall mode", data_o, 16'd30);
    tmr_i = 16'd50; cap_pin_i = 0; step(); step(); step();
    chk("R4 fall capture", data_o, 16'd50);

    phase = "R5";
    wr_ctrl(8'h06);
    for (int i = 1; i <= 4; i++) begin
      tmr_i = 16'(100 + i); pulse_pin();
      if (i == 3) chk("R5 three edges no capture", data_o, 16'd50);
    end
    chk("R5 fourth edge capture", data_o, 16'd104);
    wr_ctrl(8'h07);
    tmr_i = 16'd200;
    for (int i = 0; i < 5; i++) pulse_pin();
    wr_ctrl(8'h06);
    tmr_i = 16'd300;
    for (int i = 0; i < 3; i++) pulse_pin();
    chk("R5 count restarted on mode change", data_o, 16'd104);
    tmr_i = 16'd301; pulse_pin();
    chk("R5 capture after restart", data_o, 16'd301);
    wr_ctrl(8'h07);
    tmr_i = 16'd400;
    for (int i = 0; i < 15; i++) pulse_pin();
    chk("R5 fifteen edges no capture", data_o, 16'd301);
    tmr_i = 16'd401; pulse_pin();
    chk("R5 sixteenth edge capture", data_o, 16'd401);

    phase = "R6";
    wr_ctrl(8'h05); alt_sel_i = 1;
    tmr_i = 16'd700; alt_evt_i = 1; step(); alt_evt_i = 0;
    chk("R6 alt strobe capture", data_o, 16'd700);
    tmr_i = 16'd710; pulse_pin();
    chk("R6 pin ignored with alt source", data_o, 16'd700);
    alt_sel_i = 0;

    phase = "R3";
    clr_flag();
    wr_ctrl(8'h01);
    tmr_i = 16'd699; step(); tmr_i = 16'd700; pulse_pin();
    chk("R3 reserved no flag", flag_o, 0); chk("R3 reserved no drive", pin_oe_o, 0);
    chk("R3 reserved no capture", data_o, 16'd700);
    wr_ctrl(8'h03);
    tmr_i = 16'd699; step(); tmr_i = 16'd700; pulse_pin();
    chk("R3 reserved3 no flag", flag_o, 0); chk("R3 reserved3 no drive", pin_oe_o, 0);

    phase = "R7";
    tmr_i = 16'd0; wr_data(16'h0040);
    wr_ctrl(8'h02);
    chk("R7 entry drive", pin_oe_o, 1); chk("R7 entry level", pin_o, 0);
    tmr_i = 16'h003F; step();
    tmr_i = 16'h0040; step();
    chk("R7 toggle high", pin_o, 1); chk("R7 flag", flag_o, 1);
    step(); chk("R10 held match acts once", pin_o, 1);
    tmr_i = 16'h0041; step();
    tmr_i = 16'h0040; step(); chk("R7 toggle low", pin_o, 0);

    phase = "R8";
    tmr_i = 16'd0; clr_flag();
    wr_ctrl(8'h08); chk("R8 set mode entry low", pin_o, 0); chk("R8 drive", pin_oe_o, 1);
    tmr_i = 16'h0040; step(); chk("R8 forced high", pin_o, 1); chk("R8 flag", flag_o, 1);
    tmr_i = 16'd0; step(); chk("R8 stays high", pin_o, 1);
    wr_ctrl(8'h09); chk("R8 clear mode entry high", pin_o, 1);
    tmr_i = 16'h0040; step(); chk("R8 forced low", pin_o, 0);

    phase = "R9";
    tmr_i = 16'd0; clr_flag();
    wr_ctrl(8'h0A);
    tmr_i = 16'h0040; step();
    chk("R9 event flag", flag_o, 1); chk("R9 event no drive", pin_oe_o, 0);
    chk("R9 event no trigger", tmr_rst_o, 0);
    tmr_i = 16'd0; clr_flag();
    wr_ctrl(8'h0B);
    tmr_i = 16'h0040; step(); chk("R9 trigger pulse", tmr_rst_o, 1);
    chk("R9 trigger flag", flag_o, 1);
    step(); chk("R9 trigger one cycle", tmr_rst_o, 0);

    phase = "R12";
    tmr_i = 16'd0; clr_flag(); chk("R12 cleared", flag_o, 0);
    tmr_i = 16'h0040; flag_clr_i = 1; step(); flag_clr_i = 0;
    chk("R12 set wins over clear", flag_o, 1);
    tmr_i = 16'd0; step(); step(); chk("R12 sticky", flag_o, 1);

    phase = "R11";
    dlo_we_i = 1; wdata_i = 8'h02; step(); dlo_we_i = 0;
    wr_ctrl(8'h1C); chk("R11 pwm drive", pin_oe_o, 1);
    pwm_run(16, 9, 3, 8'h04);
    pwm_run(24, 17, -1, 8'h00);
    dlo_we_i = 1; wdata_i = 8'h00; step(); dlo_we_i = 0;
    wr_ctrl(8'h0C);
    pwm_run(8, 0, -1, 8'h00);

    phase = "R3";
    wr_ctrl(8'h00);
    chk("R3 off no drive", pin_oe_o, 0); chk("R3 off pin", pin_o, 0);

    phase = "RAND";
    for (int n = 0; n < 4000; n++) begin
      tmr_i          = 16'($urandom_range(7));
      tmr_sub_i      = 2'($urandom_range(3));
      cap_pin_i      = ($urandom_range(3) == 0) ? ~cap_pin_i : cap_pin_i;
      alt_sel_i      = ($urandom_range(15) == 0) ? ~alt_sel_i : alt_sel_i;
      alt_evt_i      = ($urandom_range(3) == 0);
      period_start_i = ($urandom_range(7) == 0);
      flag_clr_i     = ($urandom_range(5) == 0);
      ctrl_we_i      = ($urandom_range(40) == 0);
      dlo_we_i       = ($urandom_range(30) == 0);
      dhi_we_i       = ($urandom_range(60) == 0);
      wdata_i        = dhi_we_i ? 8'h00 : 8'($urandom_range(255));
      if (dlo_we_i && !ctrl_we_i) wdata_i = 8'($urandom_range(7));
      step();
    end
    ctrl_we_i = 0; dlo_we_i = 0; dhi_we_i = 0; flag_clr_i = 0;
    alt_evt_i = 0; period_start_i = 0;
    step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule